// File: doc/BRIEF.md
# Dual-Channel Pixel Stream Merger

This block takes pixels from two input channels and produces one scan-line stream for a display output, one pixel per clock while a line is active. Each channel writes pixels through a valid/data pair into its own queue. A mode input chooses how the two queues are combined. In interleave mode the output takes one pixel from channel A, then one from channel B, and repeats. In split mode the output takes channel A pixels until the A queue is empty and then takes channel B pixels for the rest of the line. While the left half is being sent, the channel B queue acts as the partial line buffer for the right half.

A line begins with a one-cycle start pulse and lasts for exactly the programmed number of output pixels. If the queue that should supply a pixel is empty, the block sends an all-zero pixel in that slot and sets a sticky underrun flag. It does not stall. A pixel that arrives at a full queue is discarded and sets a sticky overflow flag. Each flag has its own write-one-to-clear input. A frame-start pulse empties both queues and ends any line in progress. A parameter selects 18-bit or 24-bit pixels. The data path is always 24 bits wide, and in 18-bit builds the top six bits are held at zero.

Top module: `pix_merge`

## Requirements
- R1: With `mode` = 0 (interleave), output slots 0, 2, 4, … of a line take the next channel A pixel, and slots 1, 3, 5, … take the next channel B pixel.
- R2: With `mode` = 1 (split), each slot takes the next channel A pixel until a slot finds the A queue empty. From that slot to the end of the line, every slot takes channel B pixels, even if A data arrives later.
- R3: After reset, `out_valid`, `out_data` and both flags are 0. When `line_start` is sampled on a clock edge with `line_len` = N, `out_valid` is high for exactly N cycles, starting after the following clock edge.
- R4: A slot whose source queue is empty outputs 24'h000000 and still counts toward the N pixels of the line.
- R5: `udr_flag` is set by any zero-filled slot. It stays set until a cycle with `clr_udr` = 1 and no new underrun.
- R6: A pixel pushed into a full queue is discarded and the queue contents are unchanged. `ovf_flag` is set and stays set until a cycle with `clr_ovf` = 1 and no new drop.
- R7: A `frame_start` pulse empties both queues and ends any active line.
- R8: With parameter NARROW = 1, `out_data[23:18]` is always 0 and bits 17:0 carry the pushed pixel bits 17:0.
- R9: Each queue holds DEPTH pixels (default 1408) with no loss and no overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 1 | 0 = interleave, 1 = split |
| frame_start | input | 1 | Pulse: flush both queues, end the active line |
| line_start | input | 1 | Pulse: begin an output line |
| line_len | input | 12 | Pixels per output line |
| a_valid | input | 1 | Channel A pixel strobe |
| a_data | input | 24 | Channel A pixel |
| b_valid | input | 1 | Channel B pixel strobe |
| b_data | input | 24 | Channel B pixel |
| clr_ovf | input | 1 | Write-one-to-clear for the overflow flag |
| clr_udr | input | 1 | Write-one-to-clear for the underrun flag |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | 24 | Output pixel |
| ovf_flag | output | 1 | Sticky queue overflow |
| udr_flag | output | 1 | Sticky underrun |

## Verification
Faults inside the block show up at the ports in predictable ways. A wrong queue pointer or count shows up within one line: pixels come out in the wrong order, or a zero appears where a stored pixel was expected. A wrong interleave phase or split latch swaps A and B pixels in the very next slot. A wrong remaining-pixel count changes how many valid cycles the line has, and the bench sees that when it checks that every expected pixel was consumed with no extra valid cycles. The bench catches a flush that does not empty the queues, or an overflow that lets a dropped pixel in, by running a later line that would then output stale data.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int PIXW = 24;
    typedef logic [PIXW-1:0] pix_t;
    typedef enum logic {
        MERGE_INTERLEAVE = 1'b0,
        MERGE_SPLIT      = 1'b1
    } merge_mode_e;
endpackage

// File: rtl/pm_queue.sv
module pm_queue
    import pm_pkg::*;
#(
    parameter int DEPTH = 1408
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic push,
    input  pix_t wdata,
    input  logic pop,
    output pix_t rdata,
    output logic empty,
    output logic drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } q_state_t;

    q_state_t st_q, st_d;
    pix_t     mem [DEPTH];
    logic     accept, take;

    always_comb begin
        st_d   = st_q;
        accept = push && (st_q.cnt != FULL_CNT) && !flush;
        take   = pop && (st_q.cnt != '0) && !flush;
        drop   = push && (st_q.cnt == FULL_CNT) && !flush;
        if (accept) begin
            st_d.wr = (st_q.wr == LAST_PTR) ? '0 : st_q.wr + 1'b1;
        end
        if (take) begin
            st_d.rd = (st_q.rd == LAST_PTR) ? '0 : st_q.rd + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(accept) - CW'(take);
        if (flush) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[st_q.wr] <= wdata;
        end
    end

    assign rdata = mem[st_q.rd];
    assign empty = (st_q.cnt == '0);

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT);

    p_drop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !pop) |=> (st_q.cnt == FULL_CNT));

    p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/pm_select.sv
module pm_select
    import pm_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  merge_mode_e       mode,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_len,
    input  logic              a_empty,
    input  pix_t              a_data,
    input  logic              b_empty,
    input  pix_t              b_data,
    output logic              a_pop,
    output logic              b_pop,
    output logic              pix_valid,
    output pix_t              pix_data,
    output logic              underrun
);
    typedef struct packed {
        logic              active;
        logic [LINE_W-1:0] remain;
        logic              phase;
        logic              on_b;
    } sel_state_t;

    sel_state_t st_q, st_d;
    logic       use_b, src_empty;

    always_comb begin
        st_d      = st_q;
        a_pop     = 1'b0;
        b_pop     = 1'b0;
        pix_valid = 1'b0;
        pix_data  = '0;
        underrun  = 1'b0;
        if (mode == MERGE_INTERLEAVE) begin
            use_b = st_q.phase;
        end else begin
            use_b = st_q.on_b || a_empty;
        end
        src_empty = use_b ? b_empty : a_empty;

        if (st_q.active) begin
            pix_valid   = 1'b1;
            underrun    = src_empty;
            a_pop       = !use_b && !a_empty;
            b_pop       = use_b && !b_empty;
            pix_data    = src_empty ? '0 : (use_b ? b_data : a_data);
            st_d.remain = st_q.remain - 1'b1;
            st_d.active = (st_q.remain != LINE_W'(1));
            st_d.phase  = !st_q.phase;
            st_d.on_b   = (mode == MERGE_SPLIT) && use_b;
        end
        if (line_start) begin
            st_d.active = (line_len != '0);
            st_d.remain = line_len;
            st_d.phase  = 1'b0;
            st_d.on_b   = 1'b0;
        end
        if (frame_start) begin
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_remain_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.remain != '0));

    p_single_pop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_pop, b_pop}));

    p_split_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.on_b && mode == MERGE_SPLIT && st_q.remain != LINE_W'(1)
         && !line_start && !frame_start) |=> st_q.on_b);

    p_alternate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.remain != LINE_W'(1) && !line_start && !frame_start)
        |=> (st_q.phase != $past(st_q.phase)));
endmodule

// File: rtl/pix_merge.sv
module pix_merge
    import pm_pkg::*;
#(
    parameter int DEPTH  = 1408,
    parameter bit NARROW = 1'b0,
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_len,
    input  logic              a_valid,
    input  logic [23:0]       a_data,
    input  logic              b_valid,
    input  logic [23:0]       b_data,
    input  logic              clr_ovf,
    input  logic              clr_udr,
    output logic              out_valid,
    output logic [23:0]       out_data,
    output logic              ovf_flag,
    output logic              udr_flag
);
    typedef struct packed {
        logic valid;
        pix_t data;
        logic ovf;
        logic udr;
    } top_state_t;

    top_state_t st_q, st_d;
    pix_t a_in, b_in, a_rd, b_rd, sel_data;
    logic a_empty, b_empty, a_pop, b_pop, a_drop, b_drop;
    logic sel_valid, sel_udr;

    generate
        if (NARROW) begin : g_narrow
            assign a_in = {6'b0, a_data[17:0]};
            assign b_in = {6'b0, b_data[17:0]};
            p_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
                out_data[23:18] == 6'b0);
        end else begin : g_wide
            assign a_in = a_data;
            assign b_in = b_data;
        end
    endgenerate

    pm_queue #(.DEPTH(DEPTH)) u_qa (
        .clk(clk), .rst_n(rst_n), .flush(frame_start), .push(a_valid), .wdata(a_in),
        .pop(a_pop), .rdata(a_rd), .empty(a_empty), .drop(a_drop)
    );

    pm_queue #(.DEPTH(DEPTH)) u_qb (
        .clk(clk), .rst_n(rst_n), .flush(frame_start), .push(b_valid), .wdata(b_in),
        .pop(b_pop), .rdata(b_rd), .empty(b_empty), .drop(b_drop)
    );

    pm_select #(.LINE_W(LINE_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .mode(merge_mode_e'(mode)), .frame_start(frame_start),
        .line_start(line_start), .line_len(line_len),
        .a_empty(a_empty), .a_data(a_rd), .b_empty(b_empty), .b_data(b_rd),
        .a_pop(a_pop), .b_pop(b_pop), .pix_valid(sel_valid), .pix_data(sel_data),
        .underrun(sel_udr)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = sel_valid;
        st_d.data  = sel_valid ? sel_data : '0;
        st_d.ovf   = (st_q.ovf && !clr_ovf) || a_drop || b_drop;
        st_d.udr   = (st_q.udr && !clr_udr) || (sel_valid && sel_udr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;
    assign ovf_flag  = st_q.ovf;
    assign udr_flag  = st_q.udr;

    p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_udr) |=> (out_valid && out_data == '0));

    p_udr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (udr_flag && !clr_udr) |=> udr_flag);

    p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_drop || b_drop) |=> ovf_flag);

    p_frame_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !line_start) |=> !sel_valid);
endmodule

// File: tb/test_pix_merge.sv
module test_pix_merge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic        frame_start = 1'b0;
    logic        line_start = 1'b0;
    logic [11:0] line_len = '0;
    logic        a_valid = 1'b0, b_valid = 1'b0;
    logic [23:0] a_data = '0, b_data = '0;
    logic        clr_ovf = 1'b0, clr_udr = 1'b0;
    logic        out_valid, ovf_flag, udr_flag;
    logic [23:0] out_data;
    logic        n_valid, n_ovf, n_udr;
    logic [23:0] n_data;

    int checks = 0;
    int errors = 0;
    logic [23:0] exp_q[$];
    logic [23:0] exp_n[$];
    string cur_req = "R1";

    always #10 clk = ~clk;

    pix_merge i_pix_merge (
        .clk(clk), .rst_n(rst_n), .mode(mode), .frame_start(frame_start),
        .line_start(line_start), .line_len(line_len),
        .a_valid(a_valid), .a_data(a_data), .b_valid(b_valid), .b_data(b_data),
        .clr_ovf(clr_ovf), .clr_udr(clr_udr),
        .out_valid(out_valid), .out_data(out_data), .ovf_flag(ovf_flag), .udr_flag(udr_flag)
    );

    pix_merge #(.NARROW(1'b1)) i_pix_merge_18 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .frame_start(frame_start),
        .line_start(line_start), .line_len(line_len),
        .a_valid(a_valid), .a_data(a_data), .b_valid(b_valid), .b_data(b_data),
        .clr_ovf(clr_ovf), .clr_udr(clr_udr),
        .out_valid(n_valid), .out_data(n_data), .ovf_flag(n_ovf), .udr_flag(n_udr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_pix(input logic [23:0] v);
        exp_q.push_back(v);
        exp_n.push_back({6'b0, v[17:0]});
    endtask

    // Scoreboard monitor for both widths (R8 on the narrow instance)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) chk({cur_req, " extra pixel"}, 32'(out_data), 32'hDEAD);
            else chk(cur_req, 32'(out_data), 32'(exp_q.pop_front()));
        end
        if (rst_n && n_valid) begin
            if (exp_n.size() == 0) chk("R8 extra pixel", 32'(n_data), 32'hDEAD);
            else chk("R8", 32'(n_data), 32'(exp_n.pop_front()));
        end
    end

    task automatic push_a(input logic [23:0] v);
        @(negedge clk); a_valid = 1'b1; a_data = v;
        @(negedge clk); a_valid = 1'b0;
    endtask

    task automatic push_b(input logic [23:0] v);
        @(negedge clk); b_valid = 1'b1; b_data = v;
        @(negedge clk); b_valid = 1'b0;
    endtask

    task automatic run_line(input int len);
        @(negedge clk); line_start = 1'b1; line_len = 12'(len);
        @(negedge clk); line_start = 1'b0;
        repeat (len + 4) @(negedge clk);
        chk({cur_req, " R3 pixels consumed"}, 32'(exp_q.size() + exp_n.size()), 32'd0);
    endtask

    task automatic clear_udr();
        @(negedge clk); clr_udr = 1'b1;
        @(negedge clk); clr_udr = 1'b0;
        chk("R5 clear", 32'(udr_flag), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R3 watchdog expired: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 reset valid", 32'(out_valid), 32'd0);
        chk("R3 reset data", 32'(out_data), 32'd0);
        chk("R3 reset ovf", 32'(ovf_flag), 32'd0);
        chk("R3 reset udr", 32'(udr_flag), 32'd0);

        // R1 interleave
        cur_req = "R1";
        mode = 1'b0;
        for (int i = 0; i < 3; i++) push_a(24'hA00010 + 24'(i));
        for (int i = 0; i < 3; i++) push_b(24'hFC0020 + 24'(i));
        for (int i = 0; i < 3; i++) begin
            expect_pix(24'hA00010 + 24'(i));
            expect_pix(24'hFC0020 + 24'(i));
        end
        run_line(6);
        chk("R5 no underrun", 32'(udr_flag), 32'd0);

        // R2 split: A drains, then B
        cur_req = "R2";
        mode = 1'b1;
        for (int i = 0; i < 3; i++) push_a(24'h3C0100 + 24'(i));
        for (int i = 0; i < 4; i++) push_b(24'hC30200 + 24'(i));
        for (int i = 0; i < 3; i++) expect_pix(24'h3C0100 + 24'(i));
        for (int i = 0; i < 4; i++) expect_pix(24'hC30200 + 24'(i));
        run_line(7);
        chk("R5 no underrun split", 32'(udr_flag), 32'd0);

        // R4 underrun in interleave
        cur_req = "R4";
        mode = 1'b0;
        push_a(24'h111111); push_a(24'h222222); push_b(24'h333333);
        expect_pix(24'h111111); expect_pix(24'h333333);
        expect_pix(24'h222222); expect_pix(24'h000000);
        run_line(4);
        chk("R5 set", 32'(udr_flag), 32'd1);
        clear_udr();

        // R4/R2 underrun in split
        cur_req = "R4 split";
        mode = 1'b1;
        push_a(24'h444444); push_a(24'h555555); push_b(24'h666666);
        expect_pix(24'h444444); expect_pix(24'h555555); expect_pix(24'h666666);
        expect_pix(24'h000000); expect_pix(24'h000000);
        run_line(5);
        chk("R5 set split", 32'(udr_flag), 32'd1);
        clear_udr();

        // R7 frame flush
        cur_req = "R7";
        mode = 1'b0;
        for (int i = 0; i < 3; i++) begin push_a(24'h777700 + 24'(i)); push_b(24'h888800 + 24'(i)); end
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        expect_pix(24'h0); expect_pix(24'h0);
        run_line(2);
        chk("R7 flush underrun", 32'(udr_flag), 32'd1);
        clear_udr();
        push_a(24'h9ABCDE); push_b(24'h123456);
        expect_pix(24'h9ABCDE); expect_pix(24'h123456);
        run_line(2);

        // R9 capacity, R6 overflow drop
        cur_req = "R9";
        mode = 1'b1;
        for (int i = 0; i < 1408; i++) push_a(24'h400000 + 24'(i));
        chk("R9 no overflow at capacity", 32'(ovf_flag), 32'd0);
        push_a(24'hEEEEEE);
        chk("R6 overflow set", 32'(ovf_flag), 32'd1);
        for (int i = 0; i < 1408; i++) expect_pix(24'h400000 + 24'(i));
        run_line(1408);
        chk("R6 sticky", 32'(ovf_flag), 32'd1);
        @(negedge clk); clr_ovf = 1'b1;
        @(negedge clk); clr_ovf = 1'b0;
        chk("R6 clear", 32'(ovf_flag), 32'd0);
        cur_req = "R6 dropped pixel absent";
        push_b(24'h5A5A5A);
        expect_pix(24'h5A5A5A);
        run_line(1);
        chk("R5 no underrun after drop", 32'(udr_flag), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule